// File: doc/BRIEF.md
# Register-Cached Evaluation Stack

This block is the operand stack of a small stack processor. The topmost entries sit in a short window of on-chip registers, and everything deeper lives in an external memory reached through a request/acknowledge port. Commands arrive one at a time. A push carries an operand, a pop discards the top, and the four binary arithmetic commands take the two top entries, combine them and leave the result on top. Memory is touched only at the edges of the window. A push into a full window first writes the bottom register entry out, and the new value enters only after that write is acknowledged. A pop or an arithmetic command that frees a window slot while memory still holds entries reads one entry back straight away. The refilled value lands at the bottom of the window, so the window stays full for as long as memory has entries.

The controller is a three-state machine. In `ST_IDLE` it accepts a command and holds `cmd_ready` high. The transition `IDLE->SPILL` is taken on a push into a full window while memory has room. `SPILL->IDLE` is taken on `mem_ack`: the write completes, the memory pointer advances and the held operand is pushed. The transition `IDLE->FILL` follows a pop or an arithmetic command when memory is not empty. `FILL->IDLE` is taken on `mem_ack`: the read data enters the bottom free slot and the memory pointer steps back. In both memory states `cmd_ready` is low. Faulty commands are dropped and raise sticky flags, which only reset clears.

Top module: `evstk_top`

## Requirements
- R1: An accepted push (`cmd_op` = 0) with a free window slot puts `cmd_data` on `tos_data` and raises `depth` by one, both visible the cycle after acceptance.
- R2: Arithmetic codes are 2 add, 3 subtract, 4 multiply and 5 divide. With `x` the entry below the top and `y` the top, the result is `x op y` truncated to the data width. It replaces both operands, and `depth` falls by one.
- R3: A pop (`cmd_op` = 1) removes the top entry. The entry beneath it becomes `tos_data`, in last-in first-out order, including entries that went through memory.
- R4: A push into a full window writes the bottom window entry to memory with `mem_we` = 1 at address equal to the number of entries already in memory. Addresses rise from 0. `cmd_ready` stays low until `mem_ack`, and only then does the new operand appear on top.
- R5: After a pop or arithmetic command, when memory holds entries, exactly one read is issued at address (entries in memory − 1). Its data becomes the bottom window entry, and `cmd_ready` stays low until `mem_ack`.
- R6: Once raised, `mem_req` and its `mem_addr` and `mem_we` hold steady until the cycle in which `mem_ack` is seen.
- R7: No other memory traffic occurs. With a window of two entries, evaluating `a b c * + a d c * + e - /` costs exactly 4 writes and 4 reads and leaves (a+b·c)/(a+d·c−e) on top.
- R8: A pop with `depth` 0, or an arithmetic command with `depth` below 2, sets the sticky `err_underflow` and leaves the stack unchanged.
- R9: A push while both the window and the memory area (MEM_DEPTH entries) are full sets the sticky `err_overflow` and is dropped.
- R10: Division by zero yields 0 on top and sets the sticky `err_div_zero`.
- R11: After reset `depth` is 0, `cmd_ready` is 1, `mem_req` is 0 and all three flags are 0.
- R12: Codes 6 and 7 are accepted and change neither `depth` nor `tos_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (see R1–R3, R12) |
| cmd_data | input | DW | Operand for push |
| cmd_ready | output | 1 | Controller idle; a valid command is taken this cycle |
| tos_data | output | DW | Current top entry |
| depth | output | clog2(WIN+MEM_DEPTH+1) | Total entries held |
| err_underflow | output | 1 | Sticky: command lacked operands |
| err_overflow | output | 1 | Sticky: push with no room left |
| err_div_zero | output | 1 | Sticky: division by zero seen |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write (spill), 0 = read (fill) |
| mem_addr | output | clog2(MEM_DEPTH) | Memory word address |
| mem_wdata | output | DW | Spilled entry |
| mem_rdata | input | DW | Filled entry, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the request |

## Verification
The bench builds the block with a 16-bit data width, a two-entry window and a four-entry memory area. At that size the whole capacity of six entries, the overflow drop and a full drain back through memory each take only a handful of commands. The two-entry window is also the size at which the four-write, four-read cost of the reference expression is defined. The operator sweep crosses all four arithmetic codes with every ordered pair from a small set of boundary operands (0, 1, 2, 7, 0x8000, 0xFFFF), so wraparound, operand order and the zero divisor are all reached. Memory latency is switched between one and three cycles to exercise the request hold.

// File: rtl/evstk_pkg.sv
package evstk_pkg;

    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_MUL  = 3'd4,
        OP_DIV  = 3'd5,
        OP_NOP6 = 3'd6,
        OP_NOP7 = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPILL = 2'd1,
        ST_FILL  = 2'd2
    } state_e;

    typedef enum logic [2:0] {
        WA_HOLD = 3'd0,
        WA_PUSH = 3'd1,
        WA_POP  = 3'd2,
        WA_FOLD = 3'd3,
        WA_FILL = 3'd4
    } win_act_e;

endpackage

// File: rtl/evstk_alu.sv
module evstk_alu
    import evstk_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e           op,
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    output logic [DW-1:0] res,
    output logic          div_zero
);

    logic rhs_zero;
    assign rhs_zero = (rhs == '0);

    always_comb begin
        res      = '0;
        div_zero = 1'b0;
        case (op)
            OP_ADD: res = lhs + rhs;
            OP_SUB: res = lhs - rhs;
            OP_MUL: res = DW'(lhs * rhs);
            OP_DIV: begin
                if (rhs_zero) begin
                    res      = '0;
                    div_zero = 1'b1;
                end else begin
                    res = lhs / rhs;
                end
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/evstk_window.sv
module evstk_window
    import evstk_pkg::*;
#(
    parameter int DW  = 16,
    parameter int WIN = 2,
    parameter int CW  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  win_act_e      act,
    input  logic [DW-1:0] din,
    input  logic [CW-1:0] fill_idx,
    output logic [DW-1:0] top,
    output logic [DW-1:0] second,
    output logic [DW-1:0] bottom
);

    // slot 0 is the top of the stack, slot WIN-1 the oldest register entry
    logic [DW-1:0] slot [WIN];

    for (genvar i = 0; i < WIN; i++) begin : g_slot
        logic [DW-1:0] q;
        logic [DW-1:0] nxt;
        logic [DW-1:0] above;
        logic [DW-1:0] below;

        if (i == 0) begin : g_first
            assign above = din;
        end else begin : g_inner_a
            assign above = slot[i-1];
        end

        if (i == WIN - 1) begin : g_last
            assign below = q;
        end else begin : g_inner_b
            assign below = slot[i+1];
        end

        always_comb begin
            nxt = q;
            case (act)
                WA_PUSH: nxt = above;
                WA_POP:  nxt = below;
                WA_FOLD: nxt = (i == 0) ? din : below;
                WA_FILL: begin
                    if (fill_idx == CW'(i)) begin
                        nxt = din;
                    end
                end
                default: nxt = q;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                q <= nxt;
            end
        end

        assign slot[i] = q;
    end

    assign top    = slot[0];
    assign second = slot[1];
    assign bottom = slot[WIN-1];

endmodule

// File: rtl/evstk_ctrl.sv
module evstk_ctrl
    import evstk_pkg::*;
#(
    parameter int DW        = 16,
    parameter int WIN       = 2,
    parameter int MEM_DEPTH = 16,
    parameter int CW        = 2,
    parameter int SPW       = 5,
    parameter int AW        = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  op_e            cmd_op,
    input  logic [DW-1:0]  cmd_data,
    output logic           cmd_ready,
    input  logic [DW-1:0]  alu_res,
    input  logic           alu_dz,
    output win_act_e       win_act,
    output logic [DW-1:0]  win_din,
    output logic [CW-1:0]  cnt,
    output logic [SPW-1:0] sp,
    output logic           err_under,
    output logic           err_over,
    output logic           err_dz,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ack
);

    state_e         state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic [SPW-1:0] sp_q, sp_d;
    logic [DW-1:0]  pend_q, pend_d;
    logic           under_q, under_d;
    logic           over_q, over_d;
    logic           dz_q, dz_d;

    logic           win_full;
    logic           mem_full;
    logic           mem_some;
    logic           two_held;
    logic [SPW-1:0] sp_dec;

    assign win_full = (cnt_q == CW'(WIN));
    assign mem_full = (sp_q == SPW'(MEM_DEPTH));
    assign mem_some = (sp_q != '0);
    assign two_held = (cnt_q >= CW'(2));
    assign sp_dec   = sp_q - SPW'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sp_q    <= '0;
            pend_q  <= '0;
            under_q <= 1'b0;
            over_q  <= 1'b0;
            dz_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sp_q    <= sp_d;
            pend_q  <= pend_d;
            under_q <= under_d;
            over_q  <= over_d;
            dz_q    <= dz_d;
        end
    end

    // transitions and window actions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sp_d    = sp_q;
        pend_d  = pend_q;
        under_d = under_q;
        over_d  = over_q;
        dz_d    = dz_q;
        win_act = WA_HOLD;
        win_din = cmd_data;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (cmd_op)
                        OP_PUSH: begin
                            if (!win_full) begin
                                win_act = WA_PUSH;
                                cnt_d   = cnt_q + CW'(1);
                            end else if (mem_full) begin
                                over_d = 1'b1;
                            end else begin
                                pend_d  = cmd_data;
                                state_d = ST_SPILL;   // IDLE->SPILL
                            end
                        end
                        OP_POP: begin
                            if (cnt_q == '0) begin
                                under_d = 1'b1;
                            end else begin
                                win_act = WA_POP;
                                cnt_d   = cnt_q - CW'(1);
                                if (mem_some) state_d = ST_FILL;   // IDLE->FILL
                            end
                        end
                        OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
                            if (!two_held) begin
                                under_d = 1'b1;
                            end else begin
                                win_act = WA_FOLD;
                                win_din = alu_res;
                                cnt_d   = cnt_q - CW'(1);
                                if (alu_dz) dz_d = 1'b1;
                                if (mem_some) state_d = ST_FILL;   // IDLE->FILL
                            end
                        end
                        default: win_act = WA_HOLD;
                    endcase
                end
            end
            ST_SPILL: begin
                if (mem_ack) begin
                    win_act = WA_PUSH;
                    win_din = pend_q;
                    sp_d    = sp_q + SPW'(1);
                    state_d = ST_IDLE;                 // SPILL->IDLE
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    win_act = WA_FILL;
                    win_din = mem_rdata;
                    cnt_d   = cnt_q + CW'(1);
                    sp_d    = sp_dec;
                    state_d = ST_IDLE;                 // FILL->IDLE
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        unique case (state_q)
            ST_IDLE: cmd_ready = 1'b1;
            ST_SPILL: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = sp_q[AW-1:0];
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = sp_dec[AW-1:0];
            end
            default: cmd_ready = 1'b0;
        endcase
    end

    assign cnt       = cnt_q;
    assign sp        = sp_q;
    assign err_under = under_q;
    assign err_over  = over_q;
    assign err_dz    = dz_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R6
    AST_SPILL_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> cnt_q == CW'(WIN)); // R4
    AST_WINDOW_KEPT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready && sp_q != '0 |-> cnt_q == CW'(WIN)); // R5
    AST_DZ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_dz |=> err_dz); // R10
    AST_OVER_AT_CAPACITY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_over) |-> cnt_q == CW'(WIN) && sp_q == SPW'(MEM_DEPTH)); // R9

endmodule

// File: rtl/evstk_top.sv
module evstk_top
    import evstk_pkg::*;
#(
    parameter int DW        = 16,
    parameter int WIN       = 2,
    parameter int MEM_DEPTH = 16,
    localparam int CW       = $clog2(WIN + 1),
    localparam int SPW      = $clog2(MEM_DEPTH + 1),
    localparam int AW       = $clog2(MEM_DEPTH),
    localparam int DEPTH_W  = $clog2(WIN + MEM_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [DW-1:0]      cmd_data,
    output logic               cmd_ready,
    output logic [DW-1:0]      tos_data,
    output logic [DEPTH_W-1:0] depth,
    output logic               err_underflow,
    output logic               err_overflow,
    output logic               err_div_zero,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               mem_ack
);

    op_e            op;
    win_act_e       win_act;
    logic [DW-1:0]  win_din;
    logic [DW-1:0]  top_v, second_v, bottom_v;
    logic [DW-1:0]  alu_res;
    logic           alu_dz;
    logic [CW-1:0]  cnt;
    logic [SPW-1:0] sp;

    assign op = op_e'(cmd_op);

    evstk_alu #(.DW(DW)) u_alu (
        .op       (op),
        .lhs      (second_v),
        .rhs      (top_v),
        .res      (alu_res),
        .div_zero (alu_dz)
    );

    evstk_window #(.DW(DW), .WIN(WIN), .CW(CW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (win_act),
        .din      (win_din),
        .fill_idx (cnt),
        .top      (top_v),
        .second   (second_v),
        .bottom   (bottom_v)
    );

    evstk_ctrl #(
        .DW(DW), .WIN(WIN), .MEM_DEPTH(MEM_DEPTH), .CW(CW), .SPW(SPW), .AW(AW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (op),
        .cmd_data  (cmd_data),
        .cmd_ready (cmd_ready),
        .alu_res   (alu_res),
        .alu_dz    (alu_dz),
        .win_act   (win_act),
        .win_din   (win_din),
        .cnt       (cnt),
        .sp        (sp),
        .err_under (err_underflow),
        .err_over  (err_overflow),
        .err_dz    (err_div_zero),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );

    assign tos_data  = top_v;
    assign mem_wdata = bottom_v;
    assign depth     = DEPTH_W'(cnt) + DEPTH_W'(sp);

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_op == 3'd0 && cnt != CW'(WIN)
        |=> depth == $past(depth) + DEPTH_W'(1) && tos_data == $past(cmd_data)); // R1
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> !mem_req && cmd_ready); // R11

endmodule

// File: tb/sim_evstk_top.sv
`timescale 1ns/1ps
module sim_evstk_top;

    localparam int DW = 16;
    localparam int WIN = 2;
    localparam int MD = 4;
    localparam int AW = 2;
    localparam int DEPTH_W = 3;
    localparam int CAP = WIN + MD;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_valid = 1'b0;
    logic [2:0]         cmd_op = '0;
    logic [DW-1:0]      cmd_data = '0;
    logic               cmd_ready;
    logic [DW-1:0]      tos_data;
    logic [DEPTH_W-1:0] depth;
    logic               err_underflow, err_overflow, err_div_zero;
    logic               mem_req, mem_we;
    logic [AW-1:0]      mem_addr;
    logic [DW-1:0]      mem_wdata;
    logic [DW-1:0]      mem_rdata = '0;
    logic               mem_ack = 1'b0;

    always #5 clk = ~clk;

    evstk_top #(.DW(DW), .WIN(WIN), .MEM_DEPTH(MD)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_ready(cmd_ready), .tos_data(tos_data),
        .depth(depth), .err_underflow(err_underflow), .err_overflow(err_overflow),
        .err_div_zero(err_div_zero), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // external memory model with adjustable latency
    logic [DW-1:0] bmem [MD];
    int mem_lat = 1;
    int wait_cnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack  <= 1'b0;
            wait_cnt <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (wait_cnt >= mem_lat - 1) begin
                    mem_ack  <= 1'b1;
                    wait_cnt <= 0;
                    if (mem_we) bmem[mem_addr] <= mem_wdata;
                    else        mem_rdata <= bmem[mem_addr];
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end
        end
    end

    // port monitor, sampled between edges
    int wr_cnt = 0, rd_cnt = 0, hold_bad = 0, busy_bad = 0;
    logic pend_prev = 1'b0;
    logic [AW-1:0] addr_prev = '0;
    logic we_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend_prev && (!mem_req || mem_addr != addr_prev || mem_we != we_prev))
                hold_bad++;
            if (mem_req && cmd_ready) busy_bad++;
            if (mem_req && mem_ack) begin
                if (mem_we) wr_cnt++;
                else        rd_cnt++;
            end
            pend_prev = mem_req && !mem_ack;
            addr_prev = mem_addr;
            we_prev   = mem_we;
        end else begin
            pend_prev = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference stack
    logic [DW-1:0] mdl [CAP];
    int mdl_n = 0;

    function automatic logic [DW-1:0] calc(input logic [2:0] op, input logic [DW-1:0] x,
                                           input logic [DW-1:0] y);
        logic [31:0] p;
        case (op)
            3'd2: return x + y;
            3'd3: return x - y;
            3'd4: begin p = 32'(x) * 32'(y); return p[DW-1:0]; end
            3'd5: return (y == 0) ? '0 : x / y;
            default: return '0;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mdl_n = 0;
        wr_cnt = 0;
        rd_cnt = 0;
    endtask

    task automatic issue(input logic [2:0] op, input logic [DW-1:0] d);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic step(input logic [2:0] op, input logic [DW-1:0] d, input string tag);
        issue(op, d);
        if (op == 3'd0) begin
            if (mdl_n < CAP) begin mdl[mdl_n] = d; mdl_n++; end
        end else if (op == 3'd1) begin
            if (mdl_n > 0) mdl_n--;
        end else if (op >= 3'd2 && op <= 3'd5) begin
            if (mdl_n >= 2) begin
                mdl[mdl_n-2] = calc(op, mdl[mdl_n-2], mdl[mdl_n-1]);
                mdl_n--;
            end
        end
        chk({tag, " depth"}, 32'(depth), 32'(mdl_n));
        if (mdl_n > 0) chk({tag, " top"}, 32'(tos_data), 32'(mdl[mdl_n-1]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    logic [DW-1:0] vals [6] = '{16'h0000, 16'h0001, 16'h0002, 16'h0007, 16'h8000, 16'hFFFF};

    initial begin
        logic [DW-1:0] tos_before;
        logic [DW-1:0] a, b, c, d, e, num, den, expv;
        do_reset();

        // R11 reset state
        chk("R11 depth", 32'(depth), 0);
        chk("R11 ready", 32'(cmd_ready), 1);
        chk("R11 req", 32'(mem_req), 0);
        chk("R11 flags", {29'd0, err_underflow, err_overflow, err_div_zero}, 0);

        // R8 underflow cases
        step(3'd1, '0, "R8 pop-empty");
        chk("R8 flag", 32'(err_underflow), 1);
        step(3'd0, 16'd5, "R1 push");
        step(3'd2, '0, "R8 add-one-entry");
        // R12 spare codes
        tos_before = tos_data;
        step(3'd6, 16'h1234, "R12 code6");
        step(3'd7, 16'h4321, "R12 code7");
        chk("R12 top", 32'(tos_data), 32'(tos_before));
        // R10 divide by zero
        chk("R10 flag-before", 32'(err_div_zero), 0);
        step(3'd0, 16'd0, "R1 push");
        step(3'd5, '0, "R10 div0");
        chk("R10 flag", 32'(err_div_zero), 1);
        chk("R10 result", 32'(tos_data), 0);

        // R2 operator sweep
        do_reset();
        for (int op = 2; op <= 5; op++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    step(3'd0, vals[i], "R1 push-x");
                    step(3'd0, vals[j], "R1 push-y");
                    step(3'(op), '0, "R2 arith");
                    step(3'd1, '0, "R3 pop");
                end
            end
        end

        // R4 R5 R9 R3 capacity and drain with slow memory
        do_reset();
        mem_lat = 3;
        hold_bad = 0;
        busy_bad = 0;
        for (int k = 0; k < CAP; k++) step(3'd0, 16'(16'h10 + k), "R4 push-deep");
        chk("R4 writes", 32'(wr_cnt), MD);
        for (int k = 0; k < MD; k++) chk("R4 spill-order", 32'(bmem[k]), 32'(16'h10 + k));
        chk("R9 flag-before", 32'(err_overflow), 0);
        step(3'd0, 16'h99, "R9 push-full");
        chk("R9 flag", 32'(err_overflow), 1);
        for (int k = 0; k < CAP; k++) step(3'd1, '0, "R3 R5 drain");
        chk("R5 reads", 32'(rd_cnt), MD);
        chk("R6 hold", 32'(hold_bad), 0);
        chk("R4 busy", 32'(busy_bad), 0);
        mem_lat = 1;

        // R7 reference expression over several operand sets
        for (int s = 0; s < 8; s++) begin
            do_reset();
            a = 16'(3 * s + 1);
            b = 16'(s + 2);
            c = 16'(s);
            d = 16'(5 + 2 * s);
            e = (s % 3 == 0) ? 16'(a + d * c) : 16'(s);
            step(3'd0, a, "R7 a");
            step(3'd0, b, "R7 b");
            step(3'd0, c, "R7 c");
            step(3'd4, '0, "R7 mul");
            step(3'd2, '0, "R7 add");
            step(3'd0, a, "R7 a");
            step(3'd0, d, "R7 d");
            step(3'd0, c, "R7 c");
            step(3'd4, '0, "R7 mul");
            step(3'd2, '0, "R7 add");
            step(3'd0, e, "R7 e");
            step(3'd3, '0, "R7 sub");
            step(3'd5, '0, "R7 div");
            num  = 16'(a + b * c);
            den  = 16'(a + d * c - e);
            expv = (den == 0) ? '0 : num / den;
            chk("R7 result", 32'(tos_data), 32'(expv));
            chk("R7 writes", 32'(wr_cnt), 4);
            chk("R7 reads", 32'(rd_cnt), 4);
            chk("R10 flag-track", 32'(err_div_zero), (den == 0) ? 1 : 0);
        end
        chk("R6 hold-final", 32'(hold_bad), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule